// File: doc/BRIEF.md
# Target Read FIFO Agent

This block is the application-side controller that answers a target read through an active-low FIFO handshake. When the request line falls, it opens an address phase and drives its address-take strobe low. It records the command and the start address, and it reads a burst flag and a dual-address flag from two side bits. The address phase ends when the address-end flag arrives. The block then moves into a data phase. In that phase it pushes words from a small constant word table into the read FIFO, one word per cycle while its push strobe is low. It stops when the transfer-end flag marks the final word.

The push strobe is a registered output. It is allowed low in a cycle only when the FIFO reported space at the clock edge that opened that cycle. When the FIFO fills in the middle of a burst, the current word is held until space comes back. In 64-bit mode each push carries two consecutive table words. I/O reads are always 32 bits wide.

Top module: `trd_agent`

## Requirements
- R1: After reset, `addr_take_n` and `rd_push_n` are 1 and `out_word` is zero.
- R2: When `tgt_req_n` is 0 in the idle state, `addr_take_n` is 0 in the next cycle, and `rd_push_n` stays 1 through the whole address phase.
- R3: While `addr_take_n` is 0, only words with `in_sel`=1 are taken, and words with `in_sel`=0 are ignored. The first taken word supplies the command and the byte address. `in_flags[1]`=1 marks a burst and `in_flags[0]`=1 marks a dual-address cycle. In a dual-address cycle the second taken word is the upper address.
- R4: `addr_end_n`=0 while `addr_take_n` is 0 ends the address phase, so `addr_take_n` is 1 in the next cycle. `rd_push_n` can first go low one cycle after that. The two strobes are never low together.
- R5: `rq_full_n`=0 means the FIFO is full. `rd_push_n` is 0 in a cycle only if `rq_full_n` was 1 at the clock edge that opened that cycle. During a stall `out_word` keeps its value.
- R6: Table word i is {8'hA5^i, i, ~i, 8'h3C+i}, each field 8 bits. In 32-bit mode (`bus64`=0) a push carries {32'h0, word[k]}. The start index k comes from byte-address bits [IW+1:2], where IW = log2(DEPTH).
- R7: `bus64` is sampled when the request is accepted. In 64-bit mode the start index is forced even, and a push carries {word[k+1], word[k]}. A command of 4'b0010 (I/O read) always uses the 32-bit format.
- R8: Each cycle with `rd_push_n`=0 transfers one push. After it the index advances by 1 in 32-bit format and by 2 in 64-bit format, wrapping modulo DEPTH.
- R9: When `xfer_end_n`=0 during a push, `rd_push_n` is 1 from the next cycle on. No further push happens until `tgt_req_n` has returned to 1 and a new request starts.
- R10: When the burst flag is 0, the agent stops after the first push even if `xfer_end_n` never asserts.
- R11: An address is unmapped when any byte-address bit at or above IW+2 is set, when its two low bits are not zero, or when it is a dual-address cycle with a nonzero upper word. An unmapped address returns 32'hFFFF_FFFF in place of every table word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tgt_req_n | input | 1 | Target request, active low |
| cmd_in | input | 4 | Bus command for the current transfer |
| in_word | input | AW | Address word toward the application |
| in_flags | input | 2 | Side bits: [1] burst, [0] dual address |
| in_sel | input | 1 | 1 when `in_word` carries address data |
| addr_end_n | input | 1 | Last address word, active low |
| rq_full_n | input | 1 | Read FIFO full, active low |
| xfer_end_n | input | 1 | Last data word, active low |
| bus64 | input | 1 | 1 selects 64-bit data format |
| addr_take_n | output | 1 | Address-phase enable, active low |
| rd_push_n | output | 1 | Read-data push enable, active low |
| out_word | output | 64 | Data pushed toward the read FIFO |

## Verification
The assertions take several things for granted about the inputs. `xfer_end_n` is driven low only in a cycle where `rd_push_n` is low. `addr_end_n` is driven low only while `addr_take_n` is low. The request stays low until the agent has finished its data phase. The stimulus drives every input at the falling clock edge. It decides when to pulse the transfer-end flag by counting the pushes it has already seen, and it releases the request only after the push strobe has stayed high for several cycles. Each transaction is given a full-flag pattern that stalls the data phase at chosen points, and one pattern holds the FIFO full at the very start of the data phase.

// File: rtl/trd_pkg.sv
package trd_pkg;
  localparam int WORD_W = 32;
  localparam int OUT_W  = 2 * WORD_W;
  localparam logic [3:0] CMD_IO_RD = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PREP,
    ST_DATA,
    ST_DONE
  } trd_state_e;
endpackage

// File: rtl/trd_word_table.sv
module trd_word_table #(
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   word_lo,
  output logic [31:0]   word_hi
);
  logic [31:0]   tbl [DEPTH];
  logic [IW-1:0] nxt_idx;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      localparam logic [7:0] K = 8'(g);
      assign tbl[g] = {8'hA5 ^ K, K, ~K, 8'h3C + K};
    end
  endgenerate

  assign nxt_idx = rd_idx + IW'(1);
  assign word_lo = tbl[rd_idx];
  assign word_hi = tbl[nxt_idx];
endmodule

// File: rtl/trd_addr_capture.sv
module trd_addr_capture #(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          take,
  input  logic          sel,
  input  logic [AW-1:0] word,
  input  logic [1:0]    flags,
  input  logic [3:0]    cmd_in,
  output logic [3:0]    cmd_q,
  output logic          burst_q,
  output logic          mapped,
  output logic [IW-1:0] base_idx
);
  logic [1:0]    cnt_q;
  logic [AW-1:0] addr_q;
  logic          dual_q;
  logic          hi_nz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      burst_q <= 1'b0;
      dual_q  <= 1'b0;
      hi_nz_q <= 1'b0;
    end else if (clear) begin
      cnt_q   <= '0;
      hi_nz_q <= 1'b0;
    end else if (take && sel) begin
      if (cnt_q == 2'd0) begin
        cmd_q   <= cmd_in;
        addr_q  <= word;
        burst_q <= flags[1];
        dual_q  <= flags[0];
      end
      if (cnt_q == 2'd1) hi_nz_q <= |word;
      if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
    end
  end

  assign mapped   = (addr_q[AW-1:IW+2] == '0) && (addr_q[1:0] == 2'b00) && !(dual_q && hi_nz_q);
  assign base_idx = addr_q[IW+1:2];

  // R3
  first_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (take && sel && cnt_q != 2'd0) |=> $stable(addr_q));

  // R3
  unsel_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !sel && !clear) |=> ($stable(cnt_q) && $stable(addr_q)));
endmodule

// File: rtl/trd_ctrl.sv
module trd_ctrl
  import trd_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_n,
  input  logic             addr_end_n,
  input  logic             full_n,
  input  logic             last_n,
  input  logic             bus64,
  input  logic [3:0]       cmd,
  input  logic             burst,
  input  logic             mapped,
  input  logic [IW-1:0]    base_idx,
  input  logic [31:0]      word_lo,
  input  logic [31:0]      word_hi,
  output logic [IW-1:0]    rd_idx,
  output logic             cap_clear,
  output logic             cap_take,
  output logic             addr_take_n,
  output logic             rd_push_n,
  output logic [OUT_W-1:0] out_word
);
  trd_state_e       st_q;
  logic             addr_take_n_q;
  logic             rd_push_n_q;
  logic [IW-1:0]    idx_q;
  logic [OUT_W-1:0] out_word_q;
  logic             wide_q;

  logic             eff_wide;
  logic [IW-1:0]    step;
  logic [IW-1:0]    start_idx;
  logic             xfer;
  logic             finish;
  logic [OUT_W-1:0] data_word;

  assign eff_wide  = wide_q && (cmd != CMD_IO_RD);
  assign step      = eff_wide ? IW'(2) : IW'(1);
  assign start_idx = eff_wide ? {base_idx[IW-1:1], 1'b0} : base_idx;
  assign xfer      = (st_q == ST_DATA) && !rd_push_n_q;
  assign finish    = xfer && (!last_n || !burst);
  assign rd_idx    = (st_q == ST_PREP) ? start_idx : (idx_q + step);
  assign cap_clear = (st_q == ST_IDLE) && !req_n;
  assign cap_take  = (st_q == ST_ADDR);

  always_comb begin
    if (mapped) data_word = eff_wide ? {word_hi, word_lo} : {32'h0, word_lo};
    else        data_word = eff_wide ? {OUT_W{1'b1}} : {32'h0, 32'hFFFF_FFFF};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      addr_take_n_q <= 1'b1;
      rd_push_n_q   <= 1'b1;
      idx_q         <= '0;
      out_word_q    <= '0;
      wide_q        <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (!req_n) begin
          st_q          <= ST_ADDR;
          addr_take_n_q <= 1'b0;
          wide_q        <= bus64;
        end
        ST_ADDR: if (!addr_end_n) begin
          st_q          <= ST_PREP;
          addr_take_n_q <= 1'b1;
        end
        ST_PREP: begin
          idx_q       <= start_idx;
          out_word_q  <= data_word;
          rd_push_n_q <= !full_n;
          st_q        <= ST_DATA;
        end
        ST_DATA: begin
          if (finish) begin
            rd_push_n_q <= 1'b1;
            st_q        <= ST_DONE;
          end else if (xfer) begin
            idx_q       <= rd_idx;
            out_word_q  <= data_word;
            rd_push_n_q <= !full_n;
          end else begin
            rd_push_n_q <= !full_n;
          end
        end
        ST_DONE: if (req_n) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_take_n = addr_take_n_q;
  assign rd_push_n   = rd_push_n_q;
  assign out_word    = out_word_q;

  // R2
  req_take_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !req_n) |=> (!addr_take_n_q && rd_push_n_q));

  // R4
  addr_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADDR && !addr_end_n) |=> (addr_take_n_q && rd_push_n_q));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_take_n_q || rd_push_n_q));

  // R5
  push_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_push_n_q |-> $past(full_n));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && rd_push_n_q) |=> $stable(out_word_q));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && last_n && burst) |=> (idx_q == $past(idx_q) + $past(step)));

  // R9
  last_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !last_n) |=> (rd_push_n_q && st_q == ST_DONE));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |-> (rd_push_n_q && addr_take_n_q));

  // R10
  single_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !burst) |=> rd_push_n_q);
endmodule

// File: rtl/trd_agent.sv
module trd_agent
  import trd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tgt_req_n,
  input  logic [3:0]       cmd_in,
  input  logic [AW-1:0]    in_word,
  input  logic [1:0]       in_flags,
  input  logic             in_sel,
  input  logic             addr_end_n,
  input  logic             rq_full_n,
  input  logic             xfer_end_n,
  input  logic             bus64,
  output logic             addr_take_n,
  output logic             rd_push_n,
  output logic [OUT_W-1:0] out_word
);
  localparam int IW = $clog2(DEPTH);

  logic [3:0]    cmd_q;
  logic          burst_q;
  logic          mapped;
  logic [IW-1:0] base_idx;
  logic [IW-1:0] rd_idx;
  logic [31:0]   word_lo;
  logic [31:0]   word_hi;
  logic          cap_clear;
  logic          cap_take;

  trd_addr_capture #(.AW(AW), .IW(IW)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clear    (cap_clear),
    .take     (cap_take),
    .sel      (in_sel),
    .word     (in_word),
    .flags    (in_flags),
    .cmd_in   (cmd_in),
    .cmd_q    (cmd_q),
    .burst_q  (burst_q),
    .mapped   (mapped),
    .base_idx (base_idx)
  );

  trd_word_table #(.DEPTH(DEPTH), .IW(IW)) u_tbl (
    .rd_idx  (rd_idx),
    .word_lo (word_lo),
    .word_hi (word_hi)
  );

  trd_ctrl #(.IW(IW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_n       (tgt_req_n),
    .addr_end_n  (addr_end_n),
    .full_n      (rq_full_n),
    .last_n      (xfer_end_n),
    .bus64       (bus64),
    .cmd         (cmd_q),
    .burst       (burst_q),
    .mapped      (mapped),
    .base_idx    (base_idx),
    .word_lo     (word_lo),
    .word_hi     (word_hi),
    .rd_idx      (rd_idx),
    .cap_clear   (cap_clear),
    .cap_take    (cap_take),
    .addr_take_n (addr_take_n),
    .rd_push_n   (rd_push_n),
    .out_word    (out_word)
  );
endmodule

// File: tb/tb_trd_agent.sv
module tb_trd_agent;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tgt_req_n = 1'b1;
  logic [3:0]  cmd_in = '0;
  logic [31:0] in_word = '0;
  logic [1:0]  in_flags = '0;
  logic        in_sel = 1'b0;
  logic        addr_end_n = 1'b1;
  logic        rq_full_n = 1'b1;
  logic        xfer_end_n = 1'b1;
  logic        bus64 = 1'b0;
  logic        addr_take_n;
  logic        rd_push_n;
  logic [63:0] out_word;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] expq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  trd_agent #(.AW(32), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .tgt_req_n(tgt_req_n), .cmd_in(cmd_in),
    .in_word(in_word), .in_flags(in_flags), .in_sel(in_sel),
    .addr_end_n(addr_end_n), .rq_full_n(rq_full_n), .xfer_end_n(xfer_end_n),
    .bus64(bus64), .addr_take_n(addr_take_n), .rd_push_n(rd_push_n),
    .out_word(out_word)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(input int i);
    logic [7:0] k;
    k = 8'(i);
    return {8'hA5 ^ k, k, ~k, 8'h3C + k};
  endfunction

  // Scoreboard monitor: a push happens in every cycle where rd_push_n is low.
  always @(posedge clk) begin
    #1;
    if (!rst && !rd_push_n) begin
      chk(rq_full_n == 1'b1, "R5 push while full", 64'(rq_full_n), 64'd1);
      chk(addr_take_n == 1'b1, "R4 strobe overlap", 64'(addr_take_n), 64'd1);
      if (expq.size() == 0) begin
        chk(1'b0, "R9/R10 extra push", out_word, 64'h0);
      end else begin
        automatic logic [63:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        chk(out_word == e, t, out_word, e);
      end
    end
  end

  task automatic run_op(input logic [3:0] cmd, input logic [31:0] addr, input logic burst,
                        input logic dual, input logic [31:0] hi, input logic wide,
                        input logic junk, input int nwords, input logic use_last,
                        input logic [15:0] pat, input string tag);
    int nx;
    int idx;
    int cnt;
    int cyc;
    bit ew;
    bit mp;
    logic [63:0] e;
    nx  = burst ? nwords : 1;
    ew  = wide && (cmd != 4'b0010);
    mp  = (addr < 32'(DEPTH * 4)) && (addr[1:0] == 2'b00) && !(dual && hi != 0);
    idx = int'(addr >> 2) % DEPTH;
    if (ew) idx = idx & ~1;
    for (int k = 0; k < nx; k++) begin
      if (mp) e = ew ? {tword((idx + 1) % DEPTH), tword(idx)} : {32'h0, tword(idx)};
      else    e = ew ? {64{1'b1}} : {32'h0, 32'hFFFF_FFFF};
      expq.push_back(e);
      tagq.push_back(tag);
      idx = (idx + (ew ? 2 : 1)) % DEPTH;
    end

    @(negedge clk);
    tgt_req_n = 1'b0;
    bus64     = wide;
    rq_full_n = 1'b1;
    @(negedge clk);
    bus64 = ~wide;  // R7: sampled only at acceptance
    chk(addr_take_n == 1'b0, "R2 take strobe", 64'(addr_take_n), 64'd0);
    chk(rd_push_n == 1'b1, "R2 push idle in address phase", 64'(rd_push_n), 64'd1);
    if (junk) begin
      // R3: unselected word must be ignored
      in_sel = 1'b0; in_word = 32'hDEAD_BEEF; in_flags = 2'b11; cmd_in = 4'hF;
      @(negedge clk);
    end
    in_sel = 1'b1; in_word = addr; in_flags = {burst, dual}; cmd_in = cmd;
    addr_end_n = dual ? 1'b1 : 1'b0;
    if (dual) begin
      @(negedge clk);
      in_word = hi; in_flags = 2'b00; cmd_in = 4'h0; addr_end_n = 1'b0;
    end
    @(negedge clk);
    in_sel = 1'b0; addr_end_n = 1'b1; in_word = '0;
    chk(addr_take_n == 1'b1, "R4 take released", 64'(addr_take_n), 64'd1);
    chk(rd_push_n == 1'b1, "R4 no push yet", 64'(rd_push_n), 64'd1);
    rq_full_n = pat[0];
    cyc = 1;
    cnt = 0;
    while (cnt < nx) begin
      @(negedge clk);
      if (!rd_push_n) begin
        cnt++;
        xfer_end_n = (use_last && cnt == nx) ? 1'b0 : 1'b1;
      end else begin
        xfer_end_n = 1'b1;
      end
      rq_full_n = pat[cyc % 16];
      cyc++;
    end
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      xfer_end_n = 1'b1;
      rq_full_n  = 1'b1;
      chk(rd_push_n == 1'b1 && addr_take_n == 1'b1, "R9 quiet after end",
          {addr_take_n, rd_push_n}, 64'd3);
    end
    tgt_req_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R9 pushes missing", 64'(expq.size()), 64'd0);
    expq.delete();
    tagq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_take_n == 1'b1, "R1 take after reset", 64'(addr_take_n), 64'd1);
    chk(rd_push_n == 1'b1, "R1 push after reset", 64'(rd_push_n), 64'd1);
    chk(out_word == 64'h0, "R1 data after reset", out_word, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    // R6: single 32-bit memory read
    run_op(4'b0110, 32'h10, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1, 1'b1, 16'hFFFF, "R6 single word");
    // R8: burst wrapping past the top of the table, with stalls
    run_op(4'b0110, 32'h74, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 5, 1'b1, 16'b1011_0110_1101_1011, "R8 wrap burst");
    // R7: 64-bit burst from an odd index
    run_op(4'b1100, 32'h1C, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 3, 1'b1, 16'b1110_1101_0111_0101, "R7 wide burst");
    // R7: I/O read stays 32-bit in wide mode
    run_op(4'b0010, 32'h08, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 2, 1'b1, 16'hFFFF, "R7 io read");
    // R10: non-burst access, transfer-end never given
    run_op(4'b0110, 32'h20, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 4, 1'b0, 16'hFFFF, "R10 single stop");
    // R11 and R3: dual address with nonzero upper word, junk word first, FIFO full at start (R5)
    run_op(4'b0110, 32'h04, 1'b1, 1'b1, 32'h1, 1'b0, 1'b1, 2, 1'b1, 16'hFFFC, "R11 dual unmapped");
    // R3: dual address with zero upper word is mapped
    run_op(4'b1110, 32'h30, 1'b1, 1'b1, 32'h0, 1'b1, 1'b1, 2, 1'b1, 16'b1101_1011_0110_1111, "R3 dual mapped");
    // R11: misaligned byte address
    run_op(4'b0110, 32'h05, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 2, 1'b1, 16'hFFFF, "R11 misaligned");
    // R11: address beyond the table
    run_op(4'b0110, 32'h80, 1'b1, 1'b0, 32'h0, 1'b1, 1'b0, 2, 1'b1, 16'hFFFF, "R11 out of range");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule